// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block gathers the event sources of an I2C controller into a single interrupt line and a small set of bus-readable status views. Ten sticky sources are captured from one-cycle event pulses issued by the controller core. Two further sources are level-based and are recomputed every cycle by comparing the receive and transmit FIFO fill levels against programmable thresholds. A mask register selects which sources may raise the interrupt. Software can read the raw status, the mask and the masked status.

Software clears a sticky source by issuing a read to that source's own clear address. A separate clear-all address drops every sticky source in one access. When a transmit abort is signalled, the core also supplies a vector of abort reasons. The block accumulates these reasons in a dedicated register, which is zeroed only by the abort source's own clear read. One cycle after each abort event, the block pulses a flush request that tells the core to empty both FIFOs.

Top module: `i2c_irq_status`

## Requirements
- R1: The masked-status view (select code 2) equals the raw status AND the mask register (select code 1). The mask is written with `mask_we_i`/`mask_wdata_i` and takes effect on the next cycle.
- R2: A read at select code 5+k (k from 0 to 9) clears only sticky bit k, and the read returns zero. Bit k maps as follows: 0 stop seen, 1 start seen, 2 bus activity, 3 receive done, 4 transmit abort, 5 read request, 6 general call, 7 transmit overflow, 8 receive overflow, 9 receive underflow. The event input `evt_i` uses the same bit order.
- R3: A read at select code 4 clears all ten sticky bits together and leaves the abort-reason register unchanged.
- R4: An event pulse that arrives in the same cycle as a clear read of its own bit leaves that bit set afterwards.
- R5: On every transmit-abort event, `abrt_reason_i` is ORed into the abort-reason register (select code 3). The register holds its value until a read at select code 9, after which it reads zero. A reason vector that arrives with an abort event in that same cycle is retained.
- R6: Raw bit 10 is set while the receive level is greater than the receive threshold, so a threshold of 0 means one entry. No read clears this bit.
- R7: Raw bit 11 is set while the transmit level is at or below the transmit threshold. No read clears this bit.
- R8: `flush_o` is high for exactly the cycle that follows each transmit-abort event, and is low at all other times.
- R9: `irq_o` is the OR of the masked-status bits while `en_i` is 1, and is 0 while `en_i` is 0.
- R10: After reset, the sticky bits, the mask, the abort-reason register and `flush_o` are all zero. Select code 0 returns the raw status, and code 15 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; gates the interrupt line |
| evt_i | input | 10 | One-cycle event pulses for the sticky sources |
| abrt_reason_i | input | ABRT_W | Abort reasons, sampled when the abort event is high |
| rx_lvl_i | input | LVL_W | Receive FIFO fill level |
| rx_thr_i | input | LVL_W | Receive threshold |
| tx_lvl_i | input | LVL_W | Transmit FIFO fill level |
| tx_thr_i | input | LVL_W | Transmit threshold |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 12 | Mask write data |
| rd_valid_i | input | 1 | Read access strobe; clear side effects happen on this cycle's edge |
| rd_sel_i | input | 4 | Read select code |
| rd_data_o | output | DATA_W | Read data for the current select code |
| irq_o | output | 1 | Interrupt line |
| flush_o | output | 1 | FIFO flush request after an abort |

## Verification
The directed stimulus runs three scenarios. Mask writes under a fixed set of pending events show that masking changes the masked view but leaves the raw view unchanged. Single-source clears made with every other source pending show that a clear reaches exactly one bit and no neighbour. An event timed to land on its own clear cycle shows that setting wins over clearing. A sequence of two aborts with different reason vectors, followed by a clear-all and then by the abort clear, separates OR accumulation from overwriting. It also shows that the reason register survives the combined clear. Level sweeps around the thresholds cover the equal, one-above and one-below cases. A long random phase then mixes sparse events, arbitrary select codes and changing FIFO levels, with the enable toggling throughout.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_LAT = 10;
  localparam int RAW_W   = 12;
  localparam int SEL_W   = 4;

  // sticky bit positions; clear select code is SEL_CLR_BASE + bit
  localparam int B_STOP    = 0;
  localparam int B_START   = 1;
  localparam int B_ACT     = 2;
  localparam int B_RXDONE  = 3;
  localparam int B_ABORT   = 4;
  localparam int B_RDREQ   = 5;
  localparam int B_GCALL   = 6;
  localparam int B_TXOVF   = 7;
  localparam int B_RXOVF   = 8;
  localparam int B_RXUNF   = 9;
  localparam int B_RXFULL  = 10;
  localparam int B_TXEMPTY = 11;

  localparam logic [SEL_W-1:0] SEL_RAW      = 4'd0;
  localparam logic [SEL_W-1:0] SEL_MASK     = 4'd1;
  localparam logic [SEL_W-1:0] SEL_MASKED   = 4'd2;
  localparam logic [SEL_W-1:0] SEL_REASON   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_CLR_ALL  = 4'd4;
  localparam int               SEL_CLR_BASE = 5;
  localparam logic [SEL_W-1:0] SEL_CLR_ABORT = SEL_W'(SEL_CLR_BASE + B_ABORT);
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= (q_o[k] & ~clr_i[k]) | set_i[k]; // set wins
    end
  end
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic             rx_full_o,
  output logic             tx_empty_o
);
  assign rx_full_o  = rx_lvl_i > rx_thr_i;
  assign tx_empty_o = tx_lvl_i <= tx_thr_i;
endmodule

// File: rtl/irq_abort_rec.sv
module irq_abort_rec #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         abort_i,
  input  logic [W-1:0] reason_i,
  input  logic         clr_i,
  output logic [W-1:0] reason_o,
  output logic         flush_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reason_o <= '0;
      flush_o  <= 1'b0;
    end else begin
      reason_o <= (clr_i ? '0 : reason_o) | (abort_i ? reason_i : '0);
      flush_o  <= abort_i;
    end
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import irq_status_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int ABRT_W = 16,
  localparam int DATA_W = (ABRT_W > RAW_W) ? ABRT_W : RAW_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [NUM_LAT-1:0] evt_i,
  input  logic [ABRT_W-1:0]  abrt_reason_i,
  input  logic [LVL_W-1:0]   rx_lvl_i,
  input  logic [LVL_W-1:0]   rx_thr_i,
  input  logic [LVL_W-1:0]   tx_lvl_i,
  input  logic [LVL_W-1:0]   tx_thr_i,
  input  logic               mask_we_i,
  input  logic [RAW_W-1:0]   mask_wdata_i,
  input  logic               rd_valid_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o,
  output logic               flush_o
);
  logic [NUM_LAT-1:0] lat_q;
  logic [NUM_LAT-1:0] clr_vec;
  logic [RAW_W-1:0]   mask_q;
  logic [RAW_W-1:0]   raw;
  logic [RAW_W-1:0]   masked;
  logic [ABRT_W-1:0]  abrt_q;
  logic               rx_full;
  logic               tx_empty;
  logic               clr_reason;

  // per-source clear decode
  for (genvar k = 0; k < NUM_LAT; k++) begin : g_clr
    localparam logic [SEL_W-1:0] CODE = SEL_W'(SEL_CLR_BASE + k);
    assign clr_vec[k] = rd_valid_i && (rd_sel_i == CODE || rd_sel_i == SEL_CLR_ALL);
  end
  assign clr_reason = rd_valid_i && (rd_sel_i == SEL_CLR_ABORT);

  irq_latch_bank #(.N(NUM_LAT)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr_vec),
    .q_o   (lat_q)
  );

  irq_level_cmp #(.LVL_W(LVL_W)) u_lvl (
    .rx_lvl_i  (rx_lvl_i),
    .rx_thr_i  (rx_thr_i),
    .tx_lvl_i  (tx_lvl_i),
    .tx_thr_i  (tx_thr_i),
    .rx_full_o (rx_full),
    .tx_empty_o(tx_empty)
  );

  irq_abort_rec #(.W(ABRT_W)) u_abrt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (evt_i[B_ABORT]),
    .reason_i(abrt_reason_i),
    .clr_i   (clr_reason),
    .reason_o(abrt_q),
    .flush_o (flush_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_comb begin
    raw            = '0;
    raw[NUM_LAT-1:0] = lat_q;
    raw[B_RXFULL]  = rx_full;
    raw[B_TXEMPTY] = tx_empty;
  end

  assign masked = raw & mask_q;
  assign irq_o  = en_i & (|masked);

  always_comb begin
    case (rd_sel_i)
      SEL_RAW:    rd_data_o = DATA_W'(raw);
      SEL_MASK:   rd_data_o = DATA_W'(mask_q);
      SEL_MASKED: rd_data_o = DATA_W'(masked);
      SEL_REASON: rd_data_o = DATA_W'(abrt_q);
      default:    rd_data_o = '0; // clear addresses read as zero
    endcase
  end
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int ABRT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [NUM_LAT-1:0] evt_i,
  input logic               rd_valid_i,
  input logic [SEL_W-1:0]   rd_sel_i,
  input logic               irq_o,
  input logic               flush_o,
  input logic [NUM_LAT-1:0] lat_q,
  input logic [RAW_W-1:0]   mask_q,
  input logic [ABRT_W-1:0]  abrt_q
);
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);

  assert_mask_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((lat_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_sel_i == SEL_CLR_ALL && evt_i == '0) |=> (lat_q == '0));

  assert_no_spurious_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_i && evt_i == '0) |=> $stable(lat_q));

  assert_reason_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_valid_i && rd_sel_i == SEL_CLR_ABORT) && !evt_i[B_ABORT]) |=> $stable(abrt_q));

  assert_flush_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[B_ABORT] |=> flush_o);

  assert_flush_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[B_ABORT] |=> !flush_o);
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.ABRT_W(ABRT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .evt_i     (evt_i),
  .rd_valid_i(rd_valid_i),
  .rd_sel_i  (rd_sel_i),
  .irq_o     (irq_o),
  .flush_o   (flush_o),
  .lat_q     (lat_q),
  .mask_q    (mask_q),
  .abrt_q    (abrt_q)
);

// File: tb/i2c_irq_status_bench.sv
`timescale 1ns/1ps
module i2c_irq_status_bench;
  localparam int LVL_W = 6;
  localparam int ABRT_W = 16;
  localparam int DW = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic [9:0]      evt_i = '0;
  logic [15:0]     abrt_reason_i = '0;
  logic [5:0]      rx_lvl_i = '0, rx_thr_i = '0, tx_lvl_i = '0, tx_thr_i = '0;
  logic            mask_we_i = 1'b0;
  logic [11:0]     mask_wdata_i = '0;
  logic            rd_valid_i = 1'b0;
  logic [3:0]      rd_sel_i = '0;
  logic [DW-1:0]   rd_data_o;
  logic            irq_o, flush_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [9:0]  m_lat = '0;
  logic [11:0] m_mask = '0;
  logic [15:0] m_rsn = '0;
  logic        m_flush = 1'b0;

  always #2 clk_i = ~clk_i;

  i2c_irq_status #(.LVL_W(LVL_W), .ABRT_W(ABRT_W)) u_i2c_irq_status (.*);

  function automatic logic [11:0] m_raw();
    logic [11:0] r;
    r = {2'b00, m_lat};
    r[10] = rx_lvl_i > rx_thr_i;
    r[11] = tx_lvl_i <= tx_thr_i;
    return r;
  endfunction

  function automatic logic [15:0] m_rd(input logic [3:0] s);
    case (s)
      4'd0: return {4'h0, m_raw()};
      4'd1: return {4'h0, m_mask};
      4'd2: return {4'h0, m_raw() & m_mask};
      4'd3: return m_rsn;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // apply inputs at negedge, compare, advance model across one posedge
  task automatic step(input string tag, input logic [9:0] ev, input logic [15:0] src,
                      input logic rv, input logic [3:0] sel,
                      input logic mwe = 1'b0, input logic [11:0] mwd = '0);
    logic [9:0] clr;
    evt_i = ev; abrt_reason_i = src; rd_valid_i = rv; rd_sel_i = sel;
    mask_we_i = mwe; mask_wdata_i = mwd;
    #1;
    chk(tag, "rd_data", 32'(rd_data_o), 32'(m_rd(sel)));
    chk(tag, "irq", 32'(irq_o), 32'(en_i & (|(m_raw() & m_mask))));
    chk(tag, "flush", 32'(flush_o), 32'(m_flush));
    clr = '0;
    if (rv && sel == 4'd4) clr = '1;
    else if (rv && sel >= 4'd5 && sel <= 4'd14) clr = 10'(1) << (sel - 4'd5);
    @(posedge clk_i);
    m_lat = (m_lat & ~clr) | ev;
    if (rv && sel == 4'd9) m_rsn = '0;
    if (ev[4]) m_rsn = m_rsn | src;
    m_flush = ev[4];
    if (mwe) m_mask = mwd;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    step("R10", '0, '0, 0, 4'd0);
    step("R10", '0, '0, 0, 4'd1);
    step("R10", '0, '0, 0, 4'd3);
    step("R10", '0, '0, 0, 4'd15);
    en_i = 1'b1;
    tx_lvl_i = 6'd5; tx_thr_i = 6'd2;
    // R1 mask vs masked view
    step("R1", 10'h3FF, 16'h0001, 0, 4'd0);
    step("R1", '0, '0, 0, 4'd2, 1'b1, 12'h0A5);
    step("R1", '0, '0, 0, 4'd2);
    step("R1", '0, '0, 0, 4'd0, 1'b1, 12'hFFF);
    step("R9", '0, '0, 0, 4'd1);
    // R2 single-source clear
    for (int k = 0; k < 10; k++) begin
      step("R2", '0, '0, 1, 4'(5 + k));
      step("R2", '0, '0, 0, 4'd0);
      step("R2", 10'(1) << k, '0, 0, 4'd0);
    end
    // R4 event on its own clear cycle
    step("R4", 10'h004, '0, 1, 4'd7);
    step("R4", '0, '0, 0, 4'd0);
    step("R4", 10'h3FF, '0, 1, 4'd4);
    step("R4", '0, '0, 0, 4'd0);
    // R5 / R8 abort reasons and flush
    step("R5", '0, '0, 1, 4'd9);
    step("R8", 10'h010, 16'h00A1, 0, 4'd3);
    step("R8", '0, '0, 0, 4'd3);
    step("R5", 10'h010, 16'h1200, 0, 4'd3);
    step("R5", '0, '0, 0, 4'd3);
    step("R3", '0, '0, 1, 4'd4);
    step("R3", '0, '0, 0, 4'd3);
    step("R3", '0, '0, 0, 4'd0);
    step("R5", 10'h010, 16'h0040, 1, 4'd9);
    step("R5", '0, '0, 0, 4'd3);
    step("R5", '0, '0, 1, 4'd9);
    step("R5", '0, '0, 0, 4'd3);
    // R6 receive level compare
    rx_thr_i = 6'd0; rx_lvl_i = 6'd0; step("R6", '0, '0, 0, 4'd0);
    rx_lvl_i = 6'd1; step("R6", '0, '0, 0, 4'd0);
    step("R6", '0, '0, 1, 4'd4);
    step("R6", '0, '0, 0, 4'd2);
    rx_thr_i = 6'd7; rx_lvl_i = 6'd7; step("R6", '0, '0, 0, 4'd0);
    rx_lvl_i = 6'd8; step("R6", '0, '0, 0, 4'd0);
    // R7 transmit level compare
    tx_thr_i = 6'd4; tx_lvl_i = 6'd5; step("R7", '0, '0, 0, 4'd0);
    tx_lvl_i = 6'd4; step("R7", '0, '0, 0, 4'd0);
    step("R7", '0, '0, 1, 4'd4);
    tx_lvl_i = 6'd3; step("R7", '0, '0, 0, 4'd2);
    // R9 enable gating with pending sources
    step("R9", 10'h001, '0, 0, 4'd2);
    en_i = 1'b0; step("R9", '0, '0, 0, 4'd2);
    en_i = 1'b1; step("R9", '0, '0, 0, 4'd2);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] ev;
      ev = 10'($urandom) & 10'($urandom) & 10'($urandom);
      rx_lvl_i = 6'($urandom_range(0, 12)); rx_thr_i = 6'($urandom_range(0, 12));
      tx_lvl_i = 6'($urandom_range(0, 12)); tx_thr_i = 6'($urandom_range(0, 12));
      if ($urandom_range(0, 15) == 0) en_i = ~en_i;
      step("R2", ev, 16'($urandom), 1'($urandom), 4'($urandom),
           ($urandom_range(0, 20) == 0), 12'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule